// File: doc/BRIEF.md
# Symmetric-Pulse PWM Audio DAC

This block turns a stream of unsigned amplitude samples into a single-bit pulse-width-modulated waveform whose pulses are centred in each sample period. The waveform can then be low-pass filtered into an analog signal. An internal counter climbs from zero to its maximum and falls back to zero. The output is driven low when the counter meets the active compare value on the rising slope, and driven high when it meets it on the falling slope. Because the two actions mirror each other, each high pulse sits symmetrically around the bottom of the count.

Each return of the counter to zero marks the start of a new sample period. In that cycle the block raises a one-cycle request strobe, which also acts as the sample-rate timebase for the upstream source. The upstream source places its next sample on the sample input at any point before the following bottom. The block captures that sample into a shadow register on every enabled cycle. It moves the shadow value into the active compare register only on the bottom edge, so a change partway through a period never distorts the pulse being drawn. With 8-bit samples a period is 510 enabled clocks, and the mid-scale code 0x80 stands for the zero crossing of the reconstructed signal.

Top module: `pcpwm_dac`

## Requirements
- R1: While rst_ni is low, pwm_o is 1. The counter is reset to 0 on its rising slope, so the first enabled cycle after reset is a strobe cycle. The active and shadow compare values both reset to 0x80.
- R2: The counter runs 0,1,...,255,254,...,1,0 with one step per enabled clock, so the period is 510 enabled cycles. req_o is high for exactly one cycle per period: the enabled cycle in which the counter is 0.
- R3: When the counter equals the active compare value C on the rising slope (counter values 0 to 254), pwm_o is 0 from the next enabled cycle on. With a steady C, pwm_o is 1 at period offset C and 0 at offset C+1, where offset 0 is the strobe cycle.
- R4: When the counter equals C on the falling slope (counter values 255 down to 1), pwm_o is 1 from the next enabled cycle on. For a steady C between 1 and 254, pwm_o is 0 at offset 510-C and 1 at offset 511-C, which gives 2*C high cycles per period.
- R5: sample_i is captured on every enabled cycle. The value captured in the last enabled cycle before a strobe cycle becomes the active compare value at that strobe cycle's clock edge. Values that sample_i takes earlier in the period have no effect on pwm_o.
- R6: A steady compare value of 0 keeps pwm_o at 0 for the whole period.
- R7: A steady compare value of 255 keeps pwm_o at 1 for the whole period.
- R8: While en_i is low, the counter, the compare registers and pwm_o hold their values, and req_o stays 0. Counting resumes from the same position when en_i returns high.
- R9: The mid-scale code 0x80 gives 256 high cycles out of every 510.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; when low, all state is frozen |
| sample_i | input | 8 | Next amplitude sample, unsigned, 0x80 = mid-scale |
| pwm_o | output | 1 | Pulse-width-modulated output bit |
| req_o | output | 1 | One-cycle sample request at the bottom of the count |

## Verification
The assertions take for granted that en_i and sample_i change only between rising clock edges, and that reset is released while en_i is low. Given that, the counter never overruns its top and the output acts only on compare matches. The stimulus changes inputs on the falling edge and releases reset with the enable held low. It keeps the sample steady for several whole periods before each duty measurement. Mid-period sample changes and enable gaps are applied on purpose, to show that they cannot alter the period being drawn.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  typedef enum logic {
    SLOPE_UP = 1'b0,
    SLOPE_DN = 1'b1
  } slope_e;
endpackage

// File: rtl/pcpwm_tri_counter.sv
module pcpwm_tri_counter
  import pcpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output slope_e       slope_o,
  output logic         bottom_o
);
  localparam logic [W-1:0] NEAR_TOP = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  slope_e       slope_q;

  // top value is tagged falling, zero tagged rising
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      slope_q <= SLOPE_UP;
    end else if (en_i) begin
      if (slope_q == SLOPE_UP) begin
        cnt_q <= cnt_q + ONE;
        if (cnt_q == NEAR_TOP) slope_q <= SLOPE_DN;
      end else begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) slope_q <= SLOPE_UP;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign slope_o  = slope_q;
  assign bottom_o = (cnt_q == '0) && (slope_q == SLOPE_UP);
endmodule

// File: rtl/pcpwm_sample_regs.sv
module pcpwm_sample_regs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bottom_i,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] cmp_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] shadow_q;
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= MID;
      cmp_q    <= MID;
    end else if (en_i) begin
      shadow_q <= sample_i;
      if (bottom_i) cmp_q <= shadow_q;
    end
  end

  assign cmp_o = cmp_q;
endmodule

// File: rtl/pcpwm_compare.sv
module pcpwm_compare
  import pcpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  slope_e       slope_i,
  input  logic [W-1:0] cmp_i,
  output logic         pwm_o
);
  logic pwm_q;

  // rising match clears, falling match sets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pwm_q <= 1'b1;
    else if (en_i && cnt_i == cmp_i) pwm_q <= (slope_i == SLOPE_DN);
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pcpwm_dac.sv
module pcpwm_dac
  import pcpwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] sample_i,
  output logic         pwm_o,
  output logic         req_o
);
  logic [W-1:0] cnt;
  slope_e       slope;
  logic         bottom;
  logic [W-1:0] cmp;

  pcpwm_tri_counter #(.W(W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .cnt_o    (cnt),
    .slope_o  (slope),
    .bottom_o (bottom)
  );

  pcpwm_sample_regs #(.W(W)) i_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .bottom_i (bottom),
    .sample_i (sample_i),
    .cmp_o    (cmp)
  );

  pcpwm_compare #(.W(W)) i_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .cnt_i   (cnt),
    .slope_i (slope),
    .cmp_i   (cmp),
    .pwm_o   (pwm_o)
  );

  assign req_o = en_i & bottom;
endmodule

// File: rtl/pcpwm_dac_chk.sv
module pcpwm_dac_chk
  import pcpwm_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         pwm_o,
  input logic         req_o,
  input logic [W-1:0] cnt_q,
  input slope_e       slope_q,
  input logic [W-1:0] cmp_q
);
  assert_no_top_overrun_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slope_q == SLOPE_UP && cnt_q == '1));

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  assert_rise_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slope_q == SLOPE_UP && cnt_q == cmp_q) |=> !pwm_o);

  assert_fall_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && slope_q == SLOPE_DN && cnt_q == cmp_q) |=> pwm_o);

  assert_cmp_at_bottom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_q) |-> $past(req_o));

  assert_freeze_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(pwm_o) && $stable(cnt_q) && $stable(cmp_q)));

  assert_freeze_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !req_o);
endmodule

bind pcpwm_dac pcpwm_dac_chk #(.W(W)) i_pcpwm_dac_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .pwm_o   (pwm_o),
  .req_o   (req_o),
  .cnt_q   (cnt),
  .slope_q (slope),
  .cmp_q   (cmp)
);

// File: tb/test_pcpwm_dac.sv
module test_pcpwm_dac;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W    = 8;
  localparam int TOPV = (1 << W) - 1;
  localparam int PER  = 2 * TOPV;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] sample_i = 8'h80;
  logic         pwm_o;
  logic         req_o;

  pcpwm_dac #(.W(W)) i_pcpwm_dac (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .sample_i(sample_i), .pwm_o(pwm_o), .req_o(req_o)
  );

  always #10 clk_i = ~clk_i;

  int    vectors = 0;
  int    miss = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // behavioural reference: phase position within period
  int p = 0;
  int m_cmp = 128;
  int m_sh = 128;
  bit m_pwm = 1'b1;
  bit obs_pwm, obs_req;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit en, input int s);
    bit exp_req;
    int c;
    bit rising;
    @(negedge clk_i);
    en_i = en;
    sample_i = W'(s);
    #1;
    exp_req = en && (p == 0);
    vectors++;
    if (pwm_o !== m_pwm || req_o !== exp_req) begin
      miss++;
      $display("FAIL %s: pwm_o=%0b req_o=%0b expected pwm_o=%0b req_o=%0b at phase %0d",
               cur_tag, pwm_o, req_o, m_pwm, exp_req, p);
    end
    obs_pwm = pwm_o;
    obs_req = req_o;
    if (en) begin
      c = (p <= TOPV) ? p : PER - p;
      rising = (p < TOPV);
      if (c == m_cmp) m_pwm = !rising;
      if (p == 0) m_cmp = m_sh;
      m_sh = s;
      p = (p + 1) % PER;
    end
  endtask

  // one period from its strobe cycle, returns high-cycle count
  task automatic run_period(input int s, output int hi);
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      step(1'b1, s);
      if (i == 0) chk({cur_tag, " strobe at period start"}, int'(obs_req), 1);
      if (obs_pwm) hi++;
    end
  endtask

  task automatic duty_test(input string tag, input int s, input int exp_hi);
    int hi;
    cur_tag = tag;
    for (int k = 0; k < 3; k++) run_period(s, hi);
    run_period(s, hi);
    chk({tag, " high cycles per period"}, hi, exp_hi);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int hi, nreq, held;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    #1 chk("R1 pwm_o high in reset", int'(pwm_o), 1);
    chk("R1 req_o low in reset", int'(req_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cur_tag = "R1";
    step(1'b0, 8'h80);
    chk("R1 pwm_o high after reset", int'(obs_pwm), 1);
    step(1'b1, 8'h80);
    chk("R1 first enabled cycle strobes", int'(obs_req), 1);
    hi = 1;
    nreq = 1;
    for (int i = 1; i < PER; i++) begin
      step(1'b1, 8'h80);
      if (obs_pwm) hi++;
      if (obs_req) nreq++;
    end
    chk("R1 first period uses reset mid-scale", hi, 256);
    chk("R2 one strobe per 510 cycles", nreq, 1);

    duty_test("R9", 8'h80, 256);
    duty_test("R4", 8'h40, 128);
    duty_test("R4", 8'h01, 2);
    duty_test("R4", 8'hFE, 508);
    duty_test("R6", 8'h00, 0);
    duty_test("R7", 8'hFF, 510);

    // R3 / R4 edge timing with steady 0x40
    duty_test("R3", 8'h40, 128);
    cur_tag = "R3";
    for (int i = 0; i < PER; i++) begin
      step(1'b1, 8'h40);
      if (i == 8'h40)          chk("R3 high at match offset", int'(obs_pwm), 1);
      if (i == 8'h41)          chk("R3 low after rising match", int'(obs_pwm), 0);
      if (i == PER - 8'h40)    chk("R4 low at falling match offset", int'(obs_pwm), 0);
      if (i == PER - 8'h40 + 1) chk("R4 high after falling match", int'(obs_pwm), 1);
    end

    // R5: mid-period changes ignored
    cur_tag = "R5";
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      step(1'b1, (i >= 100 && i < 400) ? 8'hF0 : 8'h40);
      if (obs_pwm) hi++;
    end
    chk("R5 period unaffected by mid-period sample", hi, 128);
    run_period(8'h40, hi);
    chk("R5 next period uses final captured value", hi, 128);
    // R5: only the last cycle before strobe carries the new value
    for (int i = 0; i < PER; i++) step(1'b1, (i == PER - 1) ? 8'h20 : 8'h40);
    for (int i = 0; i < PER; i++) begin
      step(1'b1, 8'h20);
      if (i == 8'h20) chk("R5 new value high at its match", int'(obs_pwm), 1);
      if (i == 8'h21) chk("R5 new value clears after match", int'(obs_pwm), 0);
    end

    // R8: freeze while high, while low, and at the bottom
    duty_test("R8", 8'h40, 128);
    cur_tag = "R8";
    hi = 0;
    for (int i = 0; i < PER; i++) begin
      if (i == 20 || i == 80) begin
        held = int'(obs_pwm);
        nreq = 0;
        for (int k = 0; k < 30; k++) begin
          step(1'b0, 8'hFF);
          if (obs_req) nreq++;
          if (int'(obs_pwm) != held) chk("R8 pwm_o held while disabled", int'(obs_pwm), held);
        end
        chk("R8 no strobe while disabled", nreq, 0);
      end
      step(1'b1, 8'h40);
      if (obs_pwm) hi++;
    end
    chk("R8 duty preserved across freeze", hi, 128);
    nreq = 0;
    for (int k = 0; k < 25; k++) begin
      step(1'b0, 8'h00);
      if (obs_req) nreq++;
    end
    chk("R8 no strobe while frozen at bottom", nreq, 0);
    run_period(8'h40, hi);
    chk("R8 resumes at bottom with same duty", hi, 128);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule